// File: doc/BRIEF.md
# Size-Aware Compare Flag Generator

This combinational unit turns a compare into a packed condition word. It takes two operands and the result an ALU already produced for them. It looks at only the low byte, the low halfword or the full word of each value, as a 2-bit size code selects. From these it derives a zero flag, a sign flag, a signed-overflow flag and a carry/borrow flag. It then adds three derived relations: unsigned-above, signed greater and signed greater-or-equal.

The seven flags are packed into the low bits of a data-width word, and every other bit is zero. The word is meant to be written straight back into a general register, where a later branch or select can test single bits. The unit holds no state. Its output follows its inputs in the same cycle.

Top module: `cmpflag_gen`

## Requirements
- R1: Size code 0 compares on bits 7:0 (sign at bit 7), size code 1 on bits 15:0 (sign at bit 15), and size code 2 on bits 31:0 (sign at bit 31); operand and result bits above the selected width have no effect on any flag.
- R2: Size code 3 behaves exactly like size code 2 (full word).
- R3: Flag bit 0 (zero) is 1 exactly when the result, restricted to the selected width, is all zeros.
- R4: Flag bit 3 (sign) equals the result bit at the selected sign position.
- R5: Flag bit 2 (overflow) is 1 exactly when the result sign differs from operand A's sign and A's sign differs from B's sign, all at the selected sign position.
- R6: With op code 0 (add), flag bit 1 (carry) is the bit just above the selected width of the width-restricted A plus the width-restricted B.
- R7: With op code 1 (subtract), flag bit 1 is the bit just above the selected width of the width-restricted A minus the width-restricted B, computed one bit wider, so a borrow (B greater than A, unsigned) gives 1.
- R8: With op code 2 or 3 (any other operation), flag bit 1 is 0.
- R9: Flag bit 6 (above) is 1 exactly when both carry and zero are 0.
- R10: Flag bit 4 (greater-or-equal) is 1 exactly when sign equals overflow.
- R11: Flag bit 5 (greater) is 1 exactly when greater-or-equal is 1 and zero is 0.
- R12: Output bits 31:7 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First compare operand (A) |
| opb_i | input | 32 | Second compare operand (B) |
| alu_res_i | input | 32 | Result the ALU produced for A and B |
| op_i | input | 2 | Operation code: 0 add, 1 subtract, 2 and 3 other |
| size_i | input | 2 | Compare width: 0 byte, 1 halfword, 2 and 3 word |
| flags_o | output | 32 | Packed condition word |

## Verification
The case that is hardest to reach from the ports is a narrow compare whose upper operand and result bits are full of unrelated data. Random full-width values almost never make the masked byte or halfword exactly zero, and they rarely produce a borrow right at the lane edge. So the stimulus fills the upper bits with noise on purpose. It also builds operands whose low lanes are equal, or differ by one, or sit on either side of the signed minimum. In half of the random cycles it feeds back the true sum or difference, so the result stays consistent with the operands. In the other half the result is unrelated, which exercises the flags independently. The bench's reference model, computed in 64-bit integers, then has to agree on every flag at every width.

// File: rtl/cmpflag_pkg.sv
package cmpflag_pkg;

   // operation codes seen on op_i
   localparam logic [1:0] OP_ADD = 2'd0;
   localparam logic [1:0] OP_SUB = 2'd1;

   // number of flag bits in the packed word
   localparam int FLAG_N = 7;

   // packed layout, bit 0 (zero) is the last member
   typedef struct packed {
      logic above;
      logic gt;
      logic ge;
      logic sign;
      logic ovf;
      logic carry;
      logic zero;
   } cmp_flags_t;

endpackage

// File: rtl/cmpflag_size_dec.sv
module cmpflag_size_dec #(
   parameter int SIZE_W    = 2,
   parameter int NUM_LANES = 3,
   localparam int LIDX_W   = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
   input  logic [SIZE_W-1:0] size_i,
   output logic [LIDX_W-1:0] lane_o
);

   generate
      if (NUM_LANES > (1 << SIZE_W)) begin : g_bad_cfg
         $error("cmpflag_size_dec: size code cannot address every lane");
      end
   endgenerate

   // codes past the widest lane fold onto it
   always_comb begin
      if (int'(size_i) >= NUM_LANES)
         lane_o = LIDX_W'(NUM_LANES - 1);
      else
         lane_o = LIDX_W'(size_i);
   end

endmodule

// File: rtl/cmpflag_lane.sv
module cmpflag_lane
   import cmpflag_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] r_i,
   input  logic [1:0]   op_i,
   output logic         zero_o,
   output logic         sign_o,
   output logic         ovf_o,
   output logic         carry_o
);

   logic [W:0] sum_ext;
   logic [W:0] dif_ext;

   // one bit wider so the carry or borrow lands in bit W
   assign sum_ext = {1'b0, a_i} + {1'b0, b_i};
   assign dif_ext = {1'b0, a_i} - {1'b0, b_i};

   assign zero_o = (r_i == '0);
   assign sign_o = r_i[W-1];
   assign ovf_o  = (r_i[W-1] ^ a_i[W-1]) & (a_i[W-1] ^ b_i[W-1]);

   always_comb begin
      case (op_i)
         OP_ADD:  carry_o = sum_ext[W];
         OP_SUB:  carry_o = dif_ext[W];
         default: carry_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/cmpflag_pack.sv
module cmpflag_pack
   import cmpflag_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              zero_i,
   input  logic              sign_i,
   input  logic              ovf_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] word_o
);

   generate
      if (DATA_W < FLAG_N) begin : g_bad_width
         $error("cmpflag_pack: word too narrow for the flag set");
      end
   endgenerate

   cmp_flags_t fl;

   always_comb begin
      fl.zero  = zero_i;
      fl.carry = carry_i;
      fl.ovf   = ovf_i;
      fl.sign  = sign_i;
      fl.ge    = (sign_i == ovf_i);
      fl.gt    = (sign_i == ovf_i) & ~zero_i;
      fl.above = ~carry_i & ~zero_i;
   end

   assign word_o = {{(DATA_W-FLAG_N){1'b0}}, fl};

   always_comb begin
      // R9
      above_nonzero_chk: assert (!(word_o[6] && word_o[0]))
         else $error("above set with zero set");
      // R11
      gt_implies_ge_chk: assert (!word_o[5] || word_o[4])
         else $error("greater set without greater-or-equal");
      // R11
      gt_nonzero_chk: assert (!(word_o[5] && word_o[0]))
         else $error("greater set with zero set");
   end

endmodule

// File: rtl/cmpflag_gen.sv
module cmpflag_gen
   import cmpflag_pkg::*;
#(
   parameter int LANE0_W   = 8,
   parameter int NUM_LANES = 3,
   parameter int SIZE_W    = 2,
   localparam int DATA_W   = LANE0_W << (NUM_LANES - 1),
   localparam int LIDX_W   = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
   input  logic [DATA_W-1:0] opa_i,
   input  logic [DATA_W-1:0] opb_i,
   input  logic [DATA_W-1:0] alu_res_i,
   input  logic [1:0]        op_i,
   input  logic [SIZE_W-1:0] size_i,
   output logic [DATA_W-1:0] flags_o
);

   generate
      if (LANE0_W < 2) begin : g_bad_lane
         $error("cmpflag_gen: narrowest lane needs at least two bits");
      end
      if (NUM_LANES < 1) begin : g_bad_lanes
         $error("cmpflag_gen: at least one lane required");
      end
   endgenerate

   logic [LIDX_W-1:0]    lane_sel;
   logic [NUM_LANES-1:0] l_zero, l_sign, l_ovf, l_carry;
   logic                 s_zero, s_sign, s_ovf, s_carry;

   cmpflag_size_dec #(.SIZE_W(SIZE_W), .NUM_LANES(NUM_LANES)) u_dec (
      .size_i (size_i),
      .lane_o (lane_sel)
   );

   // one flag slice per supported width
   generate
      for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
         localparam int LW = LANE0_W << k;
         cmpflag_lane #(.W(LW)) u_lane (
            .a_i     (opa_i[LW-1:0]),
            .b_i     (opb_i[LW-1:0]),
            .r_i     (alu_res_i[LW-1:0]),
            .op_i    (op_i),
            .zero_o  (l_zero[k]),
            .sign_o  (l_sign[k]),
            .ovf_o   (l_ovf[k]),
            .carry_o (l_carry[k])
         );
      end
   endgenerate

   always_comb begin
      s_zero  = l_zero[lane_sel];
      s_sign  = l_sign[lane_sel];
      s_ovf   = l_ovf[lane_sel];
      s_carry = l_carry[lane_sel];
   end

   cmpflag_pack #(.DATA_W(DATA_W)) u_pack (
      .zero_i  (s_zero),
      .sign_i  (s_sign),
      .ovf_i   (s_ovf),
      .carry_i (s_carry),
      .word_o  (flags_o)
   );

   always_comb begin
      // R8
      other_op_no_carry_chk: assert (op_i == OP_ADD || op_i == OP_SUB || !flags_o[1])
         else $error("carry set for a non-arithmetic op");
      // R3
      zero_no_sign_chk: assert (!(flags_o[0] && flags_o[3]))
         else $error("zero and sign both set");
      // R12
      upper_clear_chk: assert (flags_o[DATA_W-1:FLAG_N] == '0)
         else $error("bits above the flag set are not zero");
      // R2
      fold_lane_chk: assert (int'(size_i) < NUM_LANES || int'(lane_sel) == NUM_LANES - 1)
         else $error("oversized size code not folded onto widest lane");
   end

endmodule

// File: tb/test_cmpflag_gen.sv
module test_cmpflag_gen;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] opa, opb, res;
   logic [1:0]  op, size;
   logic [31:0] flags;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   always #10 clk = ~clk;   // 50 MHz

   cmpflag_gen i_cmpflag_gen (
      .opa_i     (opa),
      .opb_i     (opb),
      .alu_res_i (res),
      .op_i      (op),
      .size_i    (size),
      .flags_o   (flags)
   );

   // behavioural reference on 64-bit integers
   function automatic logic [31:0] ref_model(input logic [31:0] a, b, r,
                                             input logic [1:0] o, s);
      longint unsigned w, m, ra, rb, rr, cy;
      bit z, sg, ah, bh, ov, ge, gt, ab;
      w  = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
      m  = (64'd1 << w) - 1;
      ra = a & m; rb = b & m; rr = r & m;
      if (o == 2'd0)      cy = ((ra + rb) >> w) & 1;
      else if (o == 2'd1) cy = ((ra - rb) >> w) & 1;
      else                cy = 0;
      z  = (rr == 0);
      sg = rr[w-1];
      ah = ra[w-1];
      bh = rb[w-1];
      ov = (sg != ah) && (ah != bh);
      ge = (sg == ov);
      gt = ge && !z;
      ab = (cy == 0) && !z;
      return {25'd0, ab, gt, ge, sg, ov, cy[0], z};
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h (a=%h b=%h r=%h op=%0d size=%0d)",
                  tag, got, exp, opa, opb, res, op, size);
      end
   endtask

   task automatic apply(input logic [31:0] a, b, r, input logic [1:0] o, s);
      logic [31:0] e;
      @(posedge clk); #1;
      opa = a; opb = b; res = r; op = o; size = s;
      @(negedge clk);
      e = ref_model(a, b, r, o, s);
      chk("R3 zero",    {31'd0, flags[0]}, {31'd0, e[0]});
      if (o == 2'd0)      chk("R6 carry-add", {31'd0, flags[1]}, {31'd0, e[1]});
      else if (o == 2'd1) chk("R7 borrow",    {31'd0, flags[1]}, {31'd0, e[1]});
      else                chk("R8 no-carry",  {31'd0, flags[1]}, {31'd0, e[1]});
      chk("R5 overflow", {31'd0, flags[2]}, {31'd0, e[2]});
      chk("R4 sign",     {31'd0, flags[3]}, {31'd0, e[3]});
      chk("R10 ge",      {31'd0, flags[4]}, {31'd0, e[4]});
      chk("R11 gt",      {31'd0, flags[5]}, {31'd0, e[5]});
      chk("R9 above",    {31'd0, flags[6]}, {31'd0, e[6]});
      chk("R12 upper",   {7'd0, flags[31:7]}, {7'd0, e[31:7]});
      if (s == 2'd3) chk("R2 fold", flags, e);
      else           chk("R1 width", flags, e);
   endtask

   function automatic logic [31:0] calc(input logic [31:0] a, b, input logic [1:0] o);
      return (o == 2'd1) ? a - b : a + b;
   endfunction

   initial begin
      opa = '0; opb = '0; res = '0; op = '0; size = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R12 reset-word", flags, 32'h0000_0011);

      // byte lane: junk above, equal low bytes
      apply(32'hDEAD_BE05, 32'h1234_5605, 32'hFFFF_FF00, 2'd1, 2'd0);
      // byte borrow: 0x01 - 0x02
      apply(32'hAAAA_AA01, 32'h5555_5502, 32'h0000_00FF, 2'd1, 2'd0);
      // byte signed overflow 0x80 - 0x01
      apply(32'h0000_0080, 32'h0000_0001, 32'h0000_007F, 2'd1, 2'd0);
      // byte add carry 0xFF + 0x01
      apply(32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 2'd0, 2'd0);
      // halfword: 0x7FFF + 1 overflow
      apply(32'hABCD_7FFF, 32'h0000_0001, 32'h1234_8000, 2'd0, 2'd1);
      // halfword zero with junk above
      apply(32'h1111_0000, 32'h2222_0000, 32'hFFFF_0000, 2'd1, 2'd1);
      // word signed min minus one
      apply(32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 2'd1, 2'd2);
      // word borrow, same with size 3
      apply(32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0002, 2'd1, 2'd2);
      apply(32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0002, 2'd1, 2'd3);
      apply(32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 2'd0, 2'd3);
      // other op: carry forced low
      apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 2'd2, 2'd2);
      apply(32'h0000_0001, 32'h0000_0002, 32'h0000_0000, 2'd3, 2'd0);

      for (int i = 0; i < 4000; i++) begin
         logic [31:0] a, b, r;
         logic [1:0]  o, s;
         a = $urandom; b = $urandom; o = 2'($urandom); s = 2'($urandom);
         case ($urandom % 4)
            0: b = {b[31:16], a[15:0]};          // equal low lanes
            1: b = {b[31:8], a[7:0] + 8'd1};     // off by one in byte
            2: a = {a[31:16], 16'h8000};         // signed minimum halfword
            default: ;
         endcase
         r = ($urandom % 2 == 0) ? calc(a, b, o) : $urandom;
         apply(a, b, r, o, s);
      end
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule